// File: doc/BRIEF.md
# Three-Tap Systolic Convolver

This block computes a sliding one-dimensional convolution with three signed weights, y_i = w1·x_i + w2·x_(i+1) + w3·x_(i+2). It is built as a row of identical weight-stationary cells. Each cell keeps one weight and does one multiply-accumulate for every sample the array accepts. Samples march down the row through two registers per cell. Partial sums march through one register per cell. Because of that two-to-one speed ratio, every partial sum meets three consecutive samples on its way to the far end.

Weights are written serially while the array is not running. Each written weight enters the first cell and pushes the older weights one cell further along. Once the array is enabled, it takes one sample on every cycle in which the sample-valid input is high. On any other cycle every cell register holds its value. Finished sums leave through a registered result port, which marks each result with a one-cycle valid pulse.

Top module: `systolic_conv3`

## Requirements
- R1: Synchronous active-high reset clears every weight, sample and partial sum, and drives `res_vld` and `res_data` to 0. If samples are streamed before any weight has been written, every result is 0.
- R2: Weights are written with `wld_vld` high while `run_en` is low, one weight per cycle. Call the three most recently written weights, oldest first, w1, w2 and w3. Then w1 multiplies the oldest sample of each window and w3 multiplies the newest.
- R3: While `run_en` is high, `wld_vld` and `wld_data` are ignored and the stored weights do not change.
- R4: While `run_en` is low, `smp_vld` and `smp_data` are ignored: no sample enters the array and no result pulse follows.
- R5: `res_data` is the full-precision two's-complement sum of the three 8-bit by 8-bit signed products, 18 bits wide. For example, all weights and samples at -128 give +49152.
- R6: After reset, and after every enable (`run_en` rising), the first four accepted samples produce no result. The fifth accepted sample produces the first result, which is the window made of accepted samples 1 to 3.
- R7: The result for the window that ends at accepted sample k has `res_vld` high in the clock cycle that follows the edge after the one that accepts sample k+2. `res_vld` is a single-cycle pulse for each such accepted sample.
- R8: A cycle with `smp_vld` low leaves all array registers unchanged. The results produced with gaps in the input stream are equal to those produced by the same samples sent without gaps.
- R9: Taking `run_en` low discards any partly filled window. After `run_en` is raised again, the first result comes only after four more accepted samples, as stated in R6.
- R10: `res_data` holds its value in every cycle in which `res_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | High: array accepts samples. Low: weight writes allowed |
| wld_vld | input | 1 | Weight write strobe (acts only while `run_en` is low) |
| wld_data | input | 8 | Signed weight pushed into the first cell |
| smp_vld | input | 1 | Sample valid; low stalls the array |
| smp_data | input | 8 | Signed input sample |
| res_vld | output | 1 | One-cycle result strobe |
| res_data | output | 18 | Signed convolution result |

## Verification
The properties assume that reset is held for at least two clock edges, so that the past values they compare are defined. They also assume that `run_en` is a level control, not a per-sample qualifier. The bench meets both assumptions. It holds reset for four cycles. It changes `run_en` only on falling clock edges and always drops `smp_vld` before doing so. It drives weight writes and samples on falling edges, so nothing races the rising edge that captures them. Weight writes are issued while the array runs only on purpose, to show that they are ignored.

// File: rtl/conv_pkg.sv
package conv_pkg;
    localparam int SMP_W    = 8;
    localparam int WGT_W    = 8;
    localparam int NTAP_DEF = 3;
    localparam int PROD_W   = SMP_W + WGT_W;
    localparam int ACC_W    = PROD_W + $clog2(NTAP_DEF + 1);

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [WGT_W-1:0] wgt_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    // values handed from one cell to its right-hand neighbour
    typedef struct packed {
        smp_t x;
        acc_t ps;
        wgt_t w;
    } lnk_t;

    function automatic acc_t mac(acc_t acc, wgt_t w, smp_t x);
        acc_t prod;
        prod = acc_t'(w) * acc_t'(x);
        return acc + prod;
    endfunction
endpackage

// File: rtl/conv_cell.sv
module conv_cell
    import conv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic wshift,
    input  lnk_t prev,
    output lnk_t nxt
);
    smp_t x_d1;
    smp_t x_d2;
    acc_t ps_q;
    wgt_t w_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_d1 <= '0;
            x_d2 <= '0;
            ps_q <= '0;
            w_q  <= '0;
        end else begin
            if (wshift) begin
                w_q <= prev.w;
            end
            if (step) begin
                x_d1 <= prev.x;
                x_d2 <= x_d1;
                ps_q <= mac(prev.ps, w_q, prev.x);
            end
        end
    end

    always_comb begin
        nxt.x  = x_d2;
        nxt.ps = ps_q;
        nxt.w  = w_q;
    end
endmodule

// File: rtl/conv_fill.sv
module conv_fill #(
    parameter int FILL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    input  logic step,
    output logic emit
);
    localparam int CW = $clog2(FILL + 1);
    localparam logic [CW-1:0] FULL = CW'(FILL);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            cnt <= '0;
        end else if (step && cnt != FULL) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign emit = step && (cnt == FULL);
endmodule

// File: rtl/systolic_conv3.sv
module systolic_conv3
    import conv_pkg::*;
#(
    parameter int N_TAPS = NTAP_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             wld_vld,
    input  logic [WGT_W-1:0] wld_data,
    input  logic             smp_vld,
    input  logic [SMP_W-1:0] smp_data,
    output logic             res_vld,
    output logic [ACC_W-1:0] res_data
);
    localparam int FILL = 2 * (N_TAPS - 1);

    logic step;
    logic wshift;
    logic emit;
    logic pend;
    lnk_t link [N_TAPS+1];
    logic [N_TAPS*WGT_W-1:0] wgt_flat;

    assign step   = smp_vld && run_en;
    assign wshift = wld_vld && !run_en;

    always_comb begin
        link[0].x  = smp_t'(smp_data);
        link[0].ps = '0;
        link[0].w  = wgt_t'(wld_data);
    end

    for (genvar k = 0; k < N_TAPS; k++) begin : g_cell
        conv_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .step   (step),
            .wshift (wshift),
            .prev   (link[k]),
            .nxt    (link[k+1])
        );
        assign wgt_flat[k*WGT_W +: WGT_W] = link[k+1].w;
    end

    conv_fill #(.FILL(FILL)) u_fill (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .step   (step),
        .emit   (emit)
    );

    // output stage drains independently of the stall
    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            res_vld  <= 1'b0;
            res_data <= '0;
        end else begin
            pend    <= emit;
            res_vld <= pend;
            if (pend) begin
                res_data <= link[N_TAPS].ps;
            end
        end
    end
endmodule

// File: rtl/systolic_conv3_chk.sv
module systolic_conv3_chk #(
    parameter int N_TAPS = 3,
    parameter int WGT_W  = 8,
    parameter int ACC_W  = 18
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    run_en,
    input logic                    smp_vld,
    input logic                    res_vld,
    input logic [ACC_W-1:0]        res_data,
    input logic [N_TAPS*WGT_W-1:0] wgt_flat
);
    localparam int FILL = 2 * (N_TAPS - 1);
    localparam int CW   = $clog2(FILL + 1) + 1;

    logic [CW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            seen <= '0;
        end else if (smp_vld && seen < CW'(FILL)) begin
            seen <= seen + 1'b1;
        end
    end

    AST_WGT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        run_en |=> $stable(wgt_flat)); // R3

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> ##2 !res_vld); // R4

    AST_FILL_GATE: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> ($past(seen, 2) >= CW'(FILL))); // R6

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> $past(smp_vld && run_en, 2)); // R7

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !res_vld |-> $stable(res_data)); // R10
endmodule

bind systolic_conv3 systolic_conv3_chk #(
    .N_TAPS (N_TAPS),
    .WGT_W  (conv_pkg::WGT_W),
    .ACC_W  (conv_pkg::ACC_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .smp_vld  (smp_vld),
    .res_vld  (res_vld),
    .res_data (res_data),
    .wgt_flat (wgt_flat)
);

// File: tb/systolic_conv3_bench.sv
`timescale 1ns/1ps
module systolic_conv3_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        run_en;
    logic        wld_vld;
    logic [7:0]  wld_data;
    logic        smp_vld;
    logic [7:0]  smp_data;
    logic        res_vld;
    logic [17:0] res_data;

    systolic_conv3 u_systolic_conv3 (
        .clk(clk), .rst(rst), .run_en(run_en),
        .wld_vld(wld_vld), .wld_data(wld_data),
        .smp_vld(smp_vld), .smp_data(smp_data),
        .res_vld(res_vld), .res_data(res_data)
    );

    always #2.5 clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    int n_pulse = 0;
    int n_acc = 0;
    bit done = 0;
    string cur_req = "R1";
    logic signed [17:0] exp_q[$];
    logic signed [17:0] last_res = '0;
    logic signed [17:0] e_val;
    int wm[3];
    int hs[5];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (res_vld) begin
                n_pulse++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected result pulse", 1, 0);
                end else begin
                    e_val = exp_q.pop_front();
                    chk($signed(res_data) == e_val, cur_req, "result value",
                        int'($signed(res_data)), int'(e_val));
                end
                last_res = $signed(res_data);
            end else begin
                chk($signed(res_data) == last_res, "R10", "held data",
                    int'($signed(res_data)), int'(last_res));
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1; run_en = 1'b0; wld_vld = 1'b0; wld_data = '0;
        smp_vld = 1'b0; smp_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 3; k++) wm[k] = 0;
        for (int k = 0; k < 5; k++) hs[k] = 0;
        n_acc = 0;
        exp_q.delete();
        last_res = '0;
        chk(res_vld == 1'b0, "R1", "res_vld after reset", int'(res_vld), 0);
        chk(res_data == '0, "R1", "res_data after reset", int'(res_data), 0);
    endtask

    task automatic set_run(input bit v);
        @(negedge clk);
        smp_vld = 1'b0;
        run_en = v;
        if (!v) n_acc = 0;
    endtask

    task automatic load_w(input int v);
        @(negedge clk);
        smp_vld = 1'b0;
        wld_vld = 1'b1;
        wld_data = 8'(v);
        if (!run_en) begin
            wm[0] = wm[1]; wm[1] = wm[2]; wm[2] = v;
        end
        @(negedge clk);
        wld_vld = 1'b0;
    endtask

    task automatic push_smp(input int v);
        @(negedge clk);
        smp_vld = 1'b1;
        smp_data = 8'(v);
        if (run_en) begin
            for (int k = 4; k > 0; k--) hs[k] = hs[k-1];
            hs[0] = v;
            if (n_acc >= 4)
                exp_q.push_back(18'(wm[0]*hs[4] + wm[1]*hs[3] + wm[2]*hs[2]));
            n_acc++;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            smp_vld = 1'b0;
            smp_data = 8'(k * 37 + 5);
        end
    endtask

    task automatic drain(input string req);
        idle(4);
        chk(exp_q.size() == 0, req, "missing results", exp_q.size(), 0);
    endtask

    // R1: cleared weights give zero results
    task automatic t_reset_zero();
        cur_req = "R1";
        set_run(1'b1);
        for (int i = 0; i < 8; i++) push_smp(i * 11 - 40);
        drain("R1");
    endtask

    // R2 / R5: asymmetric weights show the ordering
    task automatic t_basic();
        cur_req = "R2";
        set_run(1'b0);
        load_w(2); load_w(-3); load_w(5);
        set_run(1'b1);
        for (int i = 0; i < 12; i++) push_smp((i * 29) % 200 - 100);
        drain("R2");
    endtask

    // R6: four accepted samples produce nothing, the fifth produces one
    task automatic t_fill();
        int p0;
        cur_req = "R6";
        set_run(1'b0);
        set_run(1'b1);
        p0 = n_pulse;
        for (int i = 0; i < 4; i++) push_smp(i + 1);
        idle(4);
        chk(n_pulse == p0, "R6", "pulses during fill", n_pulse - p0, 0);
        push_smp(9);
        idle(4);
        chk(n_pulse == p0 + 1, "R6", "first result", n_pulse - p0, 1);
        drain("R6");
    endtask

    // R7: exact cycle of the pulse after one sample in a full array
    task automatic t_latency();
        cur_req = "R7";
        push_smp(-17);
        @(negedge clk);
        smp_vld = 1'b0;
        chk(res_vld == 1'b0, "R7", "res_vld one edge after accept", int'(res_vld), 0);
        @(negedge clk);
        chk(res_vld == 1'b1, "R7", "res_vld two edges after accept", int'(res_vld), 1);
        @(negedge clk);
        chk(res_vld == 1'b0, "R7", "single-cycle pulse", int'(res_vld), 0);
        drain("R7");
    endtask

    // R8: gaps in the stream change nothing
    task automatic t_stall();
        cur_req = "R8";
        for (int i = 0; i < 12; i++) begin
            push_smp(60 - i * 13);
            if (i % 3 == 1) idle(2);
            if (i == 7) idle(5);
        end
        drain("R8");
    endtask

    // R3: weight writes while running are ignored
    task automatic t_load_ignored();
        cur_req = "R3";
        for (int i = 0; i < 8; i++) begin
            push_smp(i * 7 - 20);
            wld_vld = 1'b1;
            wld_data = 8'(99 - i);
        end
        @(negedge clk);
        wld_vld = 1'b0;
        smp_vld = 1'b0;
        drain("R3");
    endtask

    // R4: samples while stopped are ignored
    task automatic t_idle_ignored();
        int p0;
        cur_req = "R4";
        set_run(1'b0);
        p0 = n_pulse;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            smp_vld = 1'b1;
            smp_data = 8'(100 + i);
        end
        idle(4);
        chk(n_pulse == p0, "R4", "pulses while stopped", n_pulse - p0, 0);
        set_run(1'b1);
        for (int i = 0; i < 7; i++) push_smp(3 - i * 5);
        drain("R4");
    endtask

    // R5: extreme operands
    task automatic t_extremes();
        cur_req = "R5";
        set_run(1'b0);
        load_w(-128); load_w(-128); load_w(-128);
        set_run(1'b1);
        for (int i = 0; i < 6; i++) push_smp(-128);
        chk(exp_q.size() > 0 && exp_q[0] == 18'sd49152, "R5", "model extreme", 
            exp_q.size() > 0 ? int'(exp_q[0]) : 0, 49152);
        drain("R5");
        set_run(1'b0);
        load_w(127); load_w(-128); load_w(127);
        set_run(1'b1);
        for (int i = 0; i < 8; i++) push_smp((i % 2 == 0) ? -128 : 127);
        drain("R5");
    endtask

    // R9: dropping run_en restarts the fill
    task automatic t_restart();
        int p0;
        cur_req = "R9";
        for (int i = 0; i < 3; i++) push_smp(i * 9);
        idle(2);
        set_run(1'b0);
        idle(2);
        set_run(1'b1);
        p0 = n_pulse;
        for (int i = 0; i < 4; i++) push_smp(40 - i);
        idle(4);
        chk(n_pulse == p0, "R9", "pulses after restart", n_pulse - p0, 0);
        push_smp(-7);
        idle(4);
        chk(n_pulse == p0 + 1, "R9", "first result after restart", n_pulse - p0, 1);
        drain("R9");
    endtask

    initial begin
        do_reset();
        t_reset_zero();
        t_basic();
        t_fill();
        t_latency();
        t_stall();
        t_load_ignored();
        t_idle_ignored();
        t_extremes();
        t_restart();
        do_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "R7", "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule